// File: doc/BRIEF.md
# Destination Address Filter with Multicast Hash

This block sits on the receive byte stream of an Ethernet MAC and decides, from the first six bytes of each frame, whether the frame should be kept. Those six bytes are the destination address. While they arrive the block captures them and runs a CRC-32 over them, one byte per clock. After the sixth byte it gives a verdict.

Three kinds of destination address are accepted:
- the all-ones broadcast address;
- an exact match with the programmed station address;
- a multicast address whose hash bit is set in a 64-bit table, provided hash filtering is enabled.

The hash bit is selected by the six most significant bits of the CRC. Any other address is rejected.

The verdict is a level. It stays put until the next start of frame, so downstream storage logic can sample it at any point during the rest of the frame. Software supplies the hash table as two 32-bit words, the station address as a 32-bit and a 16-bit word, and one hash enable bit. All of these are plain inputs held steady by the surrounding register block.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `done_o`, `accept_o` and `reject_o` are all 0.
- R2: The hash index is bits 31:26 of a CRC-32 with these properties:
  - the generator polynomial is 0x04C11DB7;
  - the register is preset to all ones at start of frame;
  - the register shifts toward its most significant bit;
  - each address byte enters least significant bit first;
  - there is no final inversion.

  The table is `{hash_hi_i, hash_lo_i}`. Index n in 0..31 selects `hash_lo_i[n]`, and index n in 32..63 selects `hash_hi_i[n-32]`.
- R3: A multicast address (bit 0 of the first address byte is 1) is accepted when `hash_en_i` is 1 and its table bit is 1.
- R4: With `hash_en_i` at 0, a multicast address that is neither broadcast nor the station address is rejected, whatever the table holds.
- R5: With both hash words at zero, every multicast address that is neither broadcast nor the station address is rejected.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is always accepted, whatever the hash enable and the table hold.
- R7: An address equal to the station address is always accepted. The station address is laid out as follows:
  - byte 0 (the first received) in `stn_lo_i[7:0]`, up to byte 3 in `stn_lo_i[31:24]`;
  - byte 4 in `stn_hi_i[7:0]`;
  - byte 5 in `stn_hi_i[15:8]`.

  A difference in any byte gives a reject, unless another rule accepts.
- R8: A non-multicast address that is not the station address is rejected, even when its table bit is set and hashing is enabled.
- R9: The verdict timing is as follows:
  - a byte is taken when `rx_valid_i` is 1, and idle cycles between address bytes are allowed;
  - `done_o` goes to 1 on the clock edge that samples the sixth address byte, and not earlier;
  - bytes after the sixth, and bytes before any start of frame, do not change the outputs.
- R10: The verdict holds until the next byte marked with `rx_sof_i`. That byte clears `done_o`, `accept_o` and `reject_o` on its edge and restarts address capture, even in the middle of an address.
- R11: `accept_o` and `reject_o` are never 1 together. While `done_o` is 1, exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | Marks the first byte of a frame (qualified by rx_valid_i) |
| rx_data_i | input | 8 | Receive byte |
| hash_lo_i | input | 32 | Hash table bits 31:0 |
| hash_hi_i | input | 32 | Hash table bits 63:32 |
| stn_lo_i | input | 32 | Station address bytes 0..3, byte 0 in bits 7:0 |
| stn_hi_i | input | 16 | Station address bytes 4..5, byte 4 in bits 7:0 |
| hash_en_i | input | 1 | Enables multicast hash acceptance |
| done_o | output | 1 | Verdict valid for the current frame |
| accept_o | output | 1 | Frame accepted |
| reject_o | output | 1 | Frame rejected |

## Verification
The bench programs a single table bit at the computed index and then every bit except that one, on both sides of the 31/32 word boundary. A design with the wrong CRC bit order, a missing preset or swapped hash words then rejects or accepts the wrong frames. It sends broadcast with hashing disabled and an empty table, unicast addresses whose hash bit is set, and station addresses that differ only in the last byte. These catch priority mistakes and a misplaced station byte. Idle gaps inside the address, trailing bytes, stray bytes before the first start of frame and a restart partway through an address check that the verdict lands exactly one edge after the sixth byte and is not disturbed afterwards. A design that counted idle cycles or re-triggered on later bytes would move or change it.

// File: rtl/daf_pkg.sv
package daf_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_BYTES  = 6;
    localparam int ADDR_W      = ADDR_BYTES * BYTE_W;
    localparam int STN_LO_W    = 4 * BYTE_W;
    localparam int STN_HI_W    = ADDR_W - STN_LO_W;
    localparam int CRC_W       = 32;
    localparam int HASH_IDX_W  = 6;
    localparam int HASH_TBL    = 1 << HASH_IDX_W;
    localparam int HASH_WORD_W = HASH_TBL / 2;
    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET = '1;

    typedef struct packed {
        logic bcast;
        logic station;
        logic mcast;
        logic hash_hit;
    } addr_class_t;

    typedef struct packed {
        logic done;
        logic accept;
        logic reject;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{done: 1'b0, accept: 1'b0, reject: 1'b0};

    // One byte of the shift-toward-MSB CRC, byte bits taken LSB first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic verdict_t make_verdict(input logic ok);
        verdict_t v;
        v.done   = 1'b1;
        v.accept = ok;
        v.reject = ~ok;
        return v;
    endfunction

endpackage

// File: rtl/daf_addr_capture.sv
module daf_addr_capture
    import daf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int B_W     = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic [B_W-1:0]       rx_data,
    output logic                 take,
    output logic                 first,
    output logic                 last,
    output logic [N_BYTES*B_W-1:0] addr_next
);
    localparam int CNT_W = $clog2(N_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(N_BYTES);

    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       pos;
    logic [N_BYTES*B_W-1:0] addr_q;

    // A byte is taken when it starts a frame or while the address is still open.
    assign take  = rx_valid && (rx_sof || (cnt_q < CNT_FULL));
    assign first = take && rx_sof;
    assign pos   = rx_sof ? '0 : cnt_q;
    assign last  = take && (pos == CNT_FULL - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_FULL;   // idle: stray bytes before any frame start are ignored
        end else if (take) begin
            cnt_q <= pos + 1'b1;
        end
    end

    for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
        logic sel;
        assign sel = take && (pos == CNT_W'(g));
        assign addr_next[g*B_W +: B_W] = sel ? rx_data : addr_q[g*B_W +: B_W];
        always_ff @(posedge clk) begin
            if (rst)      addr_q[g*B_W +: B_W] <= '0;
            else if (sel) addr_q[g*B_W +: B_W] <= rx_data;
        end
    end

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_FULL);
    p_last_closes_r9: assert property (@(posedge clk) disable iff (rst)
        last |=> (cnt_q == CNT_FULL));
    p_sof_restarts_r10: assert property (@(posedge clk) disable iff (rst)
        first |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/daf_crc_acc.sv
module daf_crc_acc
    import daf_pkg::*;
#(
    parameter int C_W = CRC_W,
    parameter int B_W = BYTE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  logic           first,
    input  logic [B_W-1:0] data,
    output logic [C_W-1:0] crc_next
);
    logic [C_W-1:0] crc_q;
    logic [C_W-1:0] base;

    // A new frame starts from the preset value, not from the old remainder.
    assign base     = first ? CRC_PRESET : crc_q;
    assign crc_next = take ? crc_byte(base, data) : crc_q;

    always_ff @(posedge clk) begin
        if (rst) crc_q <= CRC_PRESET;
        else     crc_q <= crc_next;
    end

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(crc_q));
endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
#(
    parameter int A_W   = ADDR_W,
    parameter int C_W   = CRC_W,
    parameter int IDX_W = HASH_IDX_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   first,
    input  logic                   last,
    input  logic [A_W-1:0]         addr_next,
    input  logic [C_W-1:0]         crc_next,
    input  logic [HASH_WORD_W-1:0] hash_lo,
    input  logic [HASH_WORD_W-1:0] hash_hi,
    input  logic [STN_LO_W-1:0]    stn_lo,
    input  logic [STN_HI_W-1:0]    stn_hi,
    input  logic                   hash_en,
    output verdict_t               verdict
);
    localparam int TBL = 1 << IDX_W;

    logic [TBL-1:0]   table_bits;
    logic [IDX_W-1:0] idx;
    logic [A_W-1:0]   station;
    addr_class_t      cls;
    logic             ok;
    verdict_t         verdict_q;

    assign table_bits = {hash_hi, hash_lo};
    assign station    = {stn_hi, stn_lo};
    assign idx        = crc_next[C_W-1 -: IDX_W];

    always_comb begin
        cls.bcast    = &addr_next;
        cls.station  = (addr_next == station);
        cls.mcast    = addr_next[0];
        cls.hash_hit = table_bits[idx];
        ok = cls.bcast || cls.station || (cls.mcast && hash_en && cls.hash_hit);
    end

    always_ff @(posedge clk) begin
        if (rst)        verdict_q <= VERDICT_IDLE;
        else if (last)  verdict_q <= make_verdict(ok);
        else if (first) verdict_q <= VERDICT_IDLE;
    end

    assign verdict = verdict_q;

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(verdict_q.accept && verdict_q.reject));
    p_done_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        verdict_q.done |-> (verdict_q.accept ^ verdict_q.reject));
    p_bcast_r6: assert property (@(posedge clk) disable iff (rst)
        (last && cls.bcast) |=> verdict_q.accept);
    p_unicast_miss_r8: assert property (@(posedge clk) disable iff (rst)
        (last && !cls.mcast && !cls.station) |=> verdict_q.reject);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (verdict_q.done && !first && !last) |=> $stable(verdict_q));
    p_sof_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (first && !last) |=> !verdict_q.done);
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
    import daf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_valid_i,
    input  logic                   rx_sof_i,
    input  logic [BYTE_W-1:0]      rx_data_i,
    input  logic [HASH_WORD_W-1:0] hash_lo_i,
    input  logic [HASH_WORD_W-1:0] hash_hi_i,
    input  logic [STN_LO_W-1:0]    stn_lo_i,
    input  logic [STN_HI_W-1:0]    stn_hi_i,
    input  logic                   hash_en_i,
    output logic                   done_o,
    output logic                   accept_o,
    output logic                   reject_o
);
    logic              take;
    logic              first;
    logic              last;
    logic [ADDR_W-1:0] addr_next;
    logic [CRC_W-1:0]  crc_next;
    verdict_t          verdict;

    daf_addr_capture #(.N_BYTES(ADDR_BYTES), .B_W(BYTE_W)) u_cap (
        .clk(clk), .rst(rst),
        .rx_valid(rx_valid_i), .rx_sof(rx_sof_i), .rx_data(rx_data_i),
        .take(take), .first(first), .last(last), .addr_next(addr_next)
    );

    daf_crc_acc #(.C_W(CRC_W), .B_W(BYTE_W)) u_crc (
        .clk(clk), .rst(rst),
        .take(take), .first(first), .data(rx_data_i),
        .crc_next(crc_next)
    );

    daf_decide #(.A_W(ADDR_W), .C_W(CRC_W), .IDX_W(HASH_IDX_W)) u_dec (
        .clk(clk), .rst(rst),
        .first(first), .last(last),
        .addr_next(addr_next), .crc_next(crc_next),
        .hash_lo(hash_lo_i), .hash_hi(hash_hi_i),
        .stn_lo(stn_lo_i), .stn_hi(stn_hi_i),
        .hash_en(hash_en_i),
        .verdict(verdict)
    );

    assign done_o   = verdict.done;
    assign accept_o = verdict.accept;
    assign reject_o = verdict.reject;

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (!done_o && !accept_o && !reject_o));
endmodule

// File: tb/sim_dest_addr_filter.sv
`timescale 1ns/1ps
module sim_dest_addr_filter;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 20240611;

    logic        clk = 0;
    logic        rst;
    logic        rx_valid_i, rx_sof_i;
    logic [7:0]  rx_data_i;
    logic [31:0] hash_lo_i, hash_hi_i, stn_lo_i;
    logic [15:0] stn_hi_i;
    logic        hash_en_i;
    logic        done_o, accept_o, reject_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dest_addr_filter u0 (
        .clk(clk), .rst(rst),
        .rx_valid_i(rx_valid_i), .rx_sof_i(rx_sof_i), .rx_data_i(rx_data_i),
        .hash_lo_i(hash_lo_i), .hash_hi_i(hash_hi_i),
        .stn_lo_i(stn_lo_i), .stn_hi_i(stn_hi_i),
        .hash_en_i(hash_en_i),
        .done_o(done_o), .accept_o(accept_o), .reject_o(reject_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Hash index from the requirement: serial bit stream, byte 0 first, each byte LSB first.
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic top = c[31];
            c = c << 1;
            if (top != a[k]) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    function automatic bit ref_accept(input logic [47:0] a);
        logic [63:0] tbl = {hash_hi_i, hash_lo_i};
        if (a == 48'hFFFF_FFFF_FFFF) return 1;
        if (a == {stn_hi_i, stn_lo_i}) return 1;
        return a[0] && hash_en_i && tbl[ref_idx(a)];
    endfunction

    task automatic idle();
        rx_valid_i = 0; rx_sof_i = 0; rx_data_i = 8'h00;
    endtask

    // Sends one destination address and checks the verdict timing and value.
    task automatic run_frame(input logic [47:0] a, input int gap_pct, input int tail, input string tag);
        bit e;
        logic [2:0] vexp;
        for (int i = 0; i < 6; i++) begin
            if (i > 0 && $urandom_range(0, 99) < gap_pct) begin
                @(negedge clk); idle();
            end
            @(negedge clk);
            if (i == 1) chk({done_o, accept_o, reject_o} == 3'b000, "R10 cleared by sof", {done_o, accept_o, reject_o}, 0);
            if (i == 5) chk(done_o == 0, "R9 no early verdict", done_o, 0);
            rx_valid_i = 1; rx_sof_i = (i == 0); rx_data_i = a[8*i +: 8];
        end
        @(negedge clk);
        idle();
        e = ref_accept(a);
        vexp = {1'b1, e, !e};
        chk({done_o, accept_o, reject_o} == vexp, tag, {done_o, accept_o, reject_o}, vexp);
        chk(!(accept_o && reject_o), "R11 exclusive", {accept_o, reject_o}, 0);
        for (int t = 0; t < tail; t++) begin
            @(negedge clk);
            rx_valid_i = 1; rx_sof_i = 0; rx_data_i = 8'($urandom);
        end
        if (tail > 0) begin
            @(negedge clk); idle();
            chk({done_o, accept_o, reject_o} == vexp, "R9 trailing bytes ignored", {done_o, accept_o, reject_o}, vexp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [5:0]  ix;
        bit          got_lo, got_hi;
        void'($urandom(SEED));
        idle();
        hash_lo_i = 0; hash_hi_i = 0; stn_lo_i = 0; stn_hi_i = 0; hash_en_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({done_o, accept_o, reject_o} == 3'b000, "R1 reset state", {done_o, accept_o, reject_o}, 0);

        // R9: stray bytes before any start of frame
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rx_valid_i = 1; rx_sof_i = 0; rx_data_i = 8'hFF;
        end
        @(negedge clk); idle();
        chk(done_o == 0, "R9 stray bytes before sof", done_o, 0);

        // R6: broadcast, hashing off, empty table
        stn_lo_i = 32'h3344_5566; stn_hi_i = 16'h1122;
        run_frame(48'hFFFF_FFFF_FFFF, 0, 0, "R6 broadcast");

        // R5: empty table rejects multicast
        a = 48'h0100_005E_0001;   // bytes 01 00 5E 00 00 01 in the flat layout below
        a = {8'h01, 8'h00, 8'h00, 8'h5E, 8'h00, 8'h01};
        hash_en_i = 1;
        run_frame(a, 0, 2, "R5 empty table");

        // R2/R3: only the indexed bit set, then all but it
        ix = ref_idx(a);
        {hash_hi_i, hash_lo_i} = 64'd1 << ix;
        run_frame(a, 0, 0, "R3 single indexed bit accepts");
        {hash_hi_i, hash_lo_i} = ~(64'd1 << ix);
        run_frame(a, 0, 0, "R2 all other bits reject");

        // R4: table full, hashing off
        {hash_hi_i, hash_lo_i} = '1; hash_en_i = 0;
        run_frame(a, 20, 1, "R4 hash disabled");

        // R7: station match and a last-byte mismatch
        run_frame({stn_hi_i, stn_lo_i}, 30, 0, "R7 station match");
        run_frame({stn_hi_i ^ 16'h0100, stn_lo_i}, 30, 0, "R7 byte5 mismatch");

        // R8: unicast miss with table full, hashing on
        hash_en_i = 1;
        run_frame(48'h0000_0000_0002 | 48'h1234_5678_9A00, 0, 0, "R8 unicast not hashed");

        // R10: restart in the middle of an address
        {hash_hi_i, hash_lo_i} = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid_i = 1; rx_sof_i = (i == 0); rx_data_i = 8'hFF;
        end
        run_frame(48'h0000_0000_0000, 0, 0, "R10 restart mid address");

        // R2: boundary on both hash words, one bit at a time
        got_lo = 0; got_hi = 0;
        for (int n = 0; n < 400 && !(got_lo && got_hi); n++) begin
            a = {16'($urandom), 32'($urandom)} | 48'h1;
            ix = ref_idx(a);
            if ((ix < 32 && !got_lo) || (ix >= 32 && !got_hi)) begin
                if (ix < 32) got_lo = 1; else got_hi = 1;
                {hash_hi_i, hash_lo_i} = 64'd1 << ix;
                run_frame(a, 10, 0, ix < 32 ? "R2 low word bit" : "R2 high word bit");
                {hash_hi_i, hash_lo_i} = 64'd1 << (ix ^ 6'h20);
                run_frame(a, 10, 0, "R2 other word same bit rejects");
            end
        end

        // Random mix
        for (int n = 0; n < 400; n++) begin
            a = {16'($urandom), 32'($urandom)};
            if ($urandom_range(0, 1)) a[0] = 1;
            hash_en_i = ($urandom_range(0, 3) != 0);
            hash_lo_i = $urandom; hash_hi_i = $urandom;
            stn_lo_i  = $urandom; stn_hi_i = 16'($urandom);
            case ($urandom_range(0, 9))
                0: a = 48'hFFFF_FFFF_FFFF;
                1, 2: a = {stn_hi_i, stn_lo_i};
                3, 4: begin
                    ix = ref_idx(a);
                    if ($urandom_range(0, 1)) {hash_hi_i, hash_lo_i} = {hash_hi_i, hash_lo_i} | (64'd1 << ix);
                    else {hash_hi_i, hash_lo_i} = {hash_hi_i, hash_lo_i} & ~(64'd1 << ix);
                end
                default: ;
            endcase
            run_frame(a, 25, $urandom_range(0, 3), "R3 R4 R6 R7 R8 random verdict");
        end

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule